// File: doc/BRIEF.md
# Floating-Point State Restore Sequencer

This block reloads the whole architectural state of a floating-point unit from a memory image. A single `start` command launches the transfer. The block fetches the image as 16-bit words over a request/response port and keeps at most one read in flight. It first reads the environment part of the image: the control word, status word, tag word, data pointer, instruction pointer and last opcode. It then reads the eight 80-bit stack registers, starting with ST(0) and ending with ST(7).

Every fetched word goes into a shadow copy. The architectural outputs are not touched until the last word has arrived. All of them are then replaced in one clock cycle, and a one-cycle `done` pulse follows. Before any memory access, the block checks the start command for three faults: a locked instruction, a disabled coprocessor and an unaligned operand. A fault reported on the memory port during the transfer aborts the sequence and leaves the architectural state untouched.

When the commit happens, the block also computes a pending-exception flag from the newly loaded control and status words. Waiting floating-point instructions see this flag. No-wait instructions never see it.

The controller moves through five named states:

- `S_IDLE`: waiting for `start`. It goes to `S_FAULT` if a pre-check fails and to `S_REQ` otherwise.
- `S_REQ`: one word request is held. It stays in `S_REQ` until a response arrives. It goes to `S_FAULT` on a memory fault, and to `S_COMMIT` once the last word is accepted.
- `S_COMMIT`: the shadow copy is written into the architectural state. It always moves on to `S_DONE`.
- `S_DONE`: the `done` pulse. It always returns to `S_IDLE`.
- `S_FAULT`: the fault pulse. It always returns to `S_IDLE`.

Top module: `fpu_restore_seq`

## Requirements
- R1: After reset the block is idle with no memory request. The control word is 0x037F, the tag word is 0xFFFF, and every other state output and the pending flag are 0.
- R2: The image is 47 words long in narrow mode (`mode32`=0) and 54 words in wide mode. Word k is read from byte address base+2k, with k rising from 0. Only one request is outstanding at a time, and its address is held until a response arrives. The word is little-endian: the byte at the lower address is bits 7:0.
- R3: In narrow mode the environment is words 0..6: control, status, tag, data pointer bits 15:0, instruction pointer bits 15:0, opcode (bits 10:0 kept), and one unused word. The pointer upper halves load as 0. In wide mode the environment is words 0..13: control at 0, status at 2, tag at 4, data pointer low and high at 6 and 7, instruction pointer low and high at 8 and 9, opcode at 10; the other words are unused.
- R4: The stack follows the environment directly. Register i takes words env+5i to env+5i+4, least significant word first. `fpu_st` bits [80i+79:80i] hold ST(i).
- R5: The architectural outputs keep their previous values for the whole transfer and all change in one cycle. `done` is high for exactly one cycle, in the cycle after that change.
- R6: If `cr_em` or `cr_ts` is set at start, `fault_code`=1 is pulsed with `fault_valid` in the next cycle. No read is issued and no state changes.
- R7: If `lock_pfx` is set at start, `fault_code`=2 is pulsed. This check outranks every other one.
- R8: If `align_chk` is set, `cpl`=3 and the base has any of its low two bits set, `fault_code`=3 is pulsed before any read. With `cpl` not equal to 3, an unaligned base restores normally.
- R9: A `mem_fault` response aborts the transfer with `fault_code`=4. No further reads follow, and neither the architectural state nor the pending flag changes.
- R10: The status word, including the condition bits 8, 9, 10 and 14, is taken verbatim from the image.
- R11: At commit, `pend_exc` becomes 1 exactly when some bit n in 0..5 is set in the loaded status word while bit n of the loaded control word is clear. The restore itself never raises `fp_exc_req`.
- R12: `fp_exc_req` is high only when `pend_exc`, `fp_issue` and not `fp_nowait` are all true.
- R13: A `start` that arrives while the block is busy is ignored. The running transfer continues at its original addresses, and only one completion occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a restore (only sampled when idle) |
| mode32 | input | 1 | 1 selects the wide 108-byte image, 0 the narrow 94-byte image |
| base_addr | input | ADDR_W | Byte address of the image |
| cr_em | input | 1 | Emulation control bit |
| cr_ts | input | 1 | Task-switched control bit |
| lock_pfx | input | 1 | The instruction carries a lock prefix |
| align_chk | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rdata | input | 16 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| mem_fault | input | 1 | Read faulted |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle completion pulse |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_code | output | 3 | 1 device unavailable, 2 invalid opcode, 3 alignment, 4 memory fault |
| fpu_ctrl | output | 16 | Control word |
| fpu_stat | output | 16 | Status word |
| fpu_tag | output | 16 | Tag word |
| fpu_dp | output | 32 | Data pointer |
| fpu_ip | output | 32 | Instruction pointer |
| fpu_opc | output | 11 | Last opcode |
| fpu_st | output | NUM_ST*REG_BYTES*8 | Stack registers, ST(0) in the low bits |
| pend_exc | output | 1 | Unmasked exception pending |
| fp_issue | input | 1 | A floating-point instruction is issuing |
| fp_nowait | input | 1 | The issuing instruction is a no-wait form |
| fp_exc_req | output | 1 | Raise the pending exception now |

## Verification
The bench builds the block with its defaults: a 32-bit address, eight stack registers of ten bytes each, and a four-byte alignment grain. These values make both image lengths (47 and 54 words) reachable, along with odd-byte base addresses that trip the alignment fault at privilege 3 and pass at privilege 0. They also allow a memory fault injected part-way through the stack. A stalling memory model exercises address holding, and a second start issued mid-transfer shows that busy-time commands are ignored.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_NM   = 3'd1,
        FLT_UD   = 3'd2,
        FLT_AC   = 3'd3,
        FLT_PF   = 3'd4
    } fault_e;

    typedef enum logic [3:0] {
        EF_CTRL,
        EF_STAT,
        EF_TAG,
        EF_DP_LO,
        EF_DP_HI,
        EF_IP_LO,
        EF_IP_HI,
        EF_OPC,
        EF_SKIP
    } env_field_e;

    localparam int WORD_W          = 16;
    localparam int ENV_WORDS_NARROW = 7;
    localparam int ENV_WORDS_WIDE   = 14;
    localparam int OPC_W           = 11;
    localparam int PTR_W           = 32;
    localparam int UM_BITS         = 6;

    // Which environment field a given word of the image feeds.
    function automatic env_field_e env_field(input logic wide, input logic [3:0] idx);
        env_field_e f;
        f = EF_SKIP;
        if (!wide) begin
            case (idx)
                4'd0:    f = EF_CTRL;
                4'd1:    f = EF_STAT;
                4'd2:    f = EF_TAG;
                4'd3:    f = EF_DP_LO;
                4'd4:    f = EF_IP_LO;
                4'd5:    f = EF_OPC;
                default: f = EF_SKIP;
            endcase
        end else begin
            case (idx)
                4'd0:    f = EF_CTRL;
                4'd2:    f = EF_STAT;
                4'd4:    f = EF_TAG;
                4'd6:    f = EF_DP_LO;
                4'd7:    f = EF_DP_HI;
                4'd8:    f = EF_IP_LO;
                4'd9:    f = EF_IP_HI;
                4'd10:   f = EF_OPC;
                default: f = EF_SKIP;
            endcase
        end
        return f;
    endfunction

endpackage

// File: rtl/fpr_precheck.sv
module fpr_precheck
    import fpr_pkg::*;
#(
    parameter int ALIGN_LG2 = 2
) (
    input  logic                 lock_pfx,
    input  logic                 cr_em,
    input  logic                 cr_ts,
    input  logic                 align_chk,
    input  logic [1:0]           cpl,
    input  logic [ALIGN_LG2-1:0] base_lo,
    output fault_e               pre_fault
);

    logic misaligned;

    assign misaligned = |base_lo;

    // Priority: locked form, then unavailable unit, then alignment.
    always_comb begin
        pre_fault = FLT_NONE;
        if (lock_pfx) begin
            pre_fault = FLT_UD;
        end else if (cr_em || cr_ts) begin
            pre_fault = FLT_NM;
        end else if (align_chk && (cpl == 2'd3) && misaligned) begin
            pre_fault = FLT_AC;
        end
    end

endmodule

// File: rtl/fpr_seq.sv
module fpr_seq
    import fpr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_ST    = 8,
    parameter int REG_WORDS = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          mode32,
    input  logic [ADDR_W-1:0]             base_addr,
    input  fault_e                        pre_fault,
    input  logic                          mem_rvalid,
    input  logic                          mem_fault,
    output logic                          mem_req,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          mode_wide,
    output logic                          shadow_clr,
    output logic                          cap_en,
    output logic                          cap_env,
    output logic [3:0]                    cap_env_idx,
    output logic [$clog2(NUM_ST)-1:0]     cap_reg,
    output logic [$clog2(REG_WORDS)-1:0]  cap_part,
    output logic                          commit,
    output logic                          busy,
    output logic                          done,
    output logic                          fault_valid,
    output fault_e                        fault_code
);

    localparam int STACK_WORDS  = NUM_ST * REG_WORDS;
    localparam int TOTAL_NARROW = ENV_WORDS_NARROW + STACK_WORDS;
    localparam int TOTAL_WIDE   = ENV_WORDS_WIDE + STACK_WORDS;
    localparam int CNT_W        = $clog2(TOTAL_WIDE + 1);
    localparam int RIDX_W       = $clog2(NUM_ST);
    localparam int PART_W       = $clog2(REG_WORDS);

    localparam logic [CNT_W-1:0]  LAST_NARROW = CNT_W'(TOTAL_NARROW - 1);
    localparam logic [CNT_W-1:0]  LAST_WIDE   = CNT_W'(TOTAL_WIDE - 1);
    localparam logic [3:0]        ENV_LAST_N  = 4'(ENV_WORDS_NARROW - 1);
    localparam logic [3:0]        ENV_LAST_W  = 4'(ENV_WORDS_WIDE - 1);
    localparam logic [PART_W-1:0] PART_LAST   = PART_W'(REG_WORDS - 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_COMMIT,
        S_DONE,
        S_FAULT
    } state_e;

    state_e              state_q, state_d;
    fault_e              flt_q, flt_d;
    logic [CNT_W-1:0]    word_q;
    logic [3:0]          env_q;
    logic                in_env_q;
    logic [RIDX_W-1:0]   reg_q;
    logic [PART_W-1:0]   part_q;
    logic                mode_q;
    logic [ADDR_W-1:0]   base_q;
    logic                last_word;
    logic                env_last;
    logic                launch;
    logic                accept;

    assign last_word = (word_q == (mode_q ? LAST_WIDE : LAST_NARROW));
    assign env_last  = (env_q == (mode_q ? ENV_LAST_W : ENV_LAST_N));
    assign launch    = (state_q == S_IDLE) && start && (pre_fault == FLT_NONE);
    assign accept    = (state_q == S_REQ) && mem_rvalid && !mem_fault;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        flt_d   = flt_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (pre_fault != FLT_NONE) begin
                        state_d = S_FAULT;
                        flt_d   = pre_fault;
                    end else begin
                        state_d = S_REQ;
                        flt_d   = FLT_NONE;
                    end
                end
            end
            S_REQ: begin
                if (mem_fault) begin
                    state_d = S_FAULT;
                    flt_d   = FLT_PF;
                end else if (mem_rvalid && last_word) begin
                    state_d = S_COMMIT;
                end
            end
            S_COMMIT: state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            S_FAULT:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            flt_q   <= FLT_NONE;
        end else begin
            state_q <= state_d;
            flt_q   <= flt_d;
        end
    end

    // Transfer position counters and latched command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            env_q    <= '0;
            in_env_q <= 1'b1;
            reg_q    <= '0;
            part_q   <= '0;
            mode_q   <= 1'b0;
            base_q   <= '0;
        end else if (launch) begin
            word_q   <= '0;
            env_q    <= '0;
            in_env_q <= 1'b1;
            reg_q    <= '0;
            part_q   <= '0;
            mode_q   <= mode32;
            base_q   <= base_addr;
        end else if (accept) begin
            word_q <= word_q + 1'b1;
            if (in_env_q) begin
                if (env_last) begin
                    in_env_q <= 1'b0;
                end else begin
                    env_q <= env_q + 1'b1;
                end
            end else if (part_q == PART_LAST) begin
                part_q <= '0;
                reg_q  <= reg_q + 1'b1;
            end else begin
                part_q <= part_q + 1'b1;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        mem_req     = 1'b0;
        commit      = 1'b0;
        done        = 1'b0;
        fault_valid = 1'b0;
        fault_code  = FLT_NONE;
        busy        = 1'b1;
        unique case (state_q)
            S_IDLE:   busy = 1'b0;
            S_REQ:    mem_req = 1'b1;
            S_COMMIT: commit = 1'b1;
            S_DONE:   done = 1'b1;
            S_FAULT: begin
                fault_valid = 1'b1;
                fault_code  = flt_q;
            end
            default:  busy = 1'b1;
        endcase
        mem_addr    = base_q + (ADDR_W'(word_q) << 1);
        mode_wide   = mode_q;
        shadow_clr  = launch;
        cap_en      = accept;
        cap_env     = in_env_q;
        cap_env_idx = env_q;
        cap_reg     = reg_q;
        cap_part    = part_q;
    end

    // Request address held until a response arrives
    p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid && !mem_fault) |=> (mem_req && $stable(mem_addr)))
        else $error("request dropped or address moved without response");

    // Memory fault aborts with code 4 and no further read
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_fault) |=> (fault_valid && (fault_code == FLT_PF) && !mem_req))
        else $error("memory fault did not abort");

    // Completion pulse lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done wider than one cycle");

    // A start while busy does not disturb the running request
    p_busy_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && start && !mem_rvalid && !mem_fault) |=> $stable(mem_addr))
        else $error("start while busy moved the address");

endmodule

// File: rtl/fpr_shadow.sv
module fpr_shadow
    import fpr_pkg::*;
#(
    parameter int          NUM_ST     = 8,
    parameter int          REG_WORDS  = 5,
    parameter logic [15:0] RESET_CTRL = 16'h037F,
    parameter logic [15:0] RESET_TAG  = 16'hFFFF
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    mode_wide,
    input  logic                                    shadow_clr,
    input  logic                                    cap_en,
    input  logic                                    cap_env,
    input  logic [3:0]                              cap_env_idx,
    input  logic [$clog2(NUM_ST)-1:0]               cap_reg,
    input  logic [$clog2(REG_WORDS)-1:0]            cap_part,
    input  logic [WORD_W-1:0]                       cap_data,
    input  logic                                    commit,
    output logic [WORD_W-1:0]                       sh_ctrl,
    output logic [WORD_W-1:0]                       sh_stat,
    output logic [WORD_W-1:0]                       arch_ctrl,
    output logic [WORD_W-1:0]                       arch_stat,
    output logic [WORD_W-1:0]                       arch_tag,
    output logic [PTR_W-1:0]                        arch_dp,
    output logic [PTR_W-1:0]                        arch_ip,
    output logic [OPC_W-1:0]                        arch_opc,
    output logic [NUM_ST-1:0][REG_WORDS*WORD_W-1:0] arch_st
);

    localparam int REG_W  = REG_WORDS * WORD_W;
    localparam int PART_W = $clog2(REG_WORDS);

    logic [WORD_W-1:0]             sh_tag;
    logic [PTR_W-1:0]              sh_dp;
    logic [PTR_W-1:0]              sh_ip;
    logic [OPC_W-1:0]              sh_opc;
    logic [NUM_ST-1:0][REG_W-1:0]  sh_st;

    // Shadow capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_ctrl <= '0;
            sh_stat <= '0;
            sh_tag  <= '0;
            sh_dp   <= '0;
            sh_ip   <= '0;
            sh_opc  <= '0;
            sh_st   <= '0;
        end else if (shadow_clr) begin
            sh_ctrl <= '0;
            sh_stat <= '0;
            sh_tag  <= '0;
            sh_dp   <= '0;
            sh_ip   <= '0;
            sh_opc  <= '0;
            sh_st   <= '0;
        end else if (cap_en) begin
            if (cap_env) begin
                case (env_field(mode_wide, cap_env_idx))
                    EF_CTRL:  sh_ctrl         <= cap_data;
                    EF_STAT:  sh_stat         <= cap_data;
                    EF_TAG:   sh_tag          <= cap_data;
                    EF_DP_LO: sh_dp[15:0]     <= cap_data;
                    EF_DP_HI: sh_dp[31:16]    <= cap_data;
                    EF_IP_LO: sh_ip[15:0]     <= cap_data;
                    EF_IP_HI: sh_ip[31:16]    <= cap_data;
                    EF_OPC:   sh_opc          <= cap_data[OPC_W-1:0];
                    default:  sh_opc          <= sh_opc;
                endcase
            end else begin
                for (int p = 0; p < REG_WORDS; p++) begin
                    if (cap_part == PART_W'(p)) begin
                        sh_st[cap_reg][p*WORD_W +: WORD_W] <= cap_data;
                    end
                end
            end
        end
    end

    // Architectural state, replaced in one cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arch_ctrl <= RESET_CTRL;
            arch_stat <= '0;
            arch_tag  <= RESET_TAG;
            arch_dp   <= '0;
            arch_ip   <= '0;
            arch_opc  <= '0;
            arch_st   <= '0;
        end else if (commit) begin
            arch_ctrl <= sh_ctrl;
            arch_stat <= sh_stat;
            arch_tag  <= sh_tag;
            arch_dp   <= sh_dp;
            arch_ip   <= sh_ip;
            arch_opc  <= sh_opc;
            arch_st   <= sh_st;
        end
    end

    // State only changes on commit
    p_arch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(arch_ctrl) && $stable(arch_stat) && $stable(arch_tag)
                     && $stable(arch_dp) && $stable(arch_ip) && $stable(arch_opc)
                     && $stable(arch_st)))
        else $error("architectural state changed outside commit");

    // Status word arrives verbatim
    p_stat_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (arch_stat == $past(sh_stat)))
        else $error("status word not loaded verbatim");

endmodule

// File: rtl/fpr_pend.sv
module fpr_pend
    import fpr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [UM_BITS-1:0] ld_ctrl_mask,
    input  logic [UM_BITS-1:0] ld_stat_flags,
    input  logic               fp_issue,
    input  logic               fp_nowait,
    output logic               pend,
    output logic               exc_req
);

    logic unmasked;

    assign unmasked = |(ld_stat_flags & ~ld_ctrl_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (commit) begin
            pend <= unmasked;
        end
    end

    assign exc_req = pend && fp_issue && !fp_nowait;

    // Raised only for a waiting instruction
    p_no_spont_exc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (fp_issue && !fp_nowait))
        else $error("exception raised without waiting instruction");

    // Flag only moves at commit
    p_pend_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(pend))
        else $error("pending flag moved outside commit");

    p_nowait_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_issue && fp_nowait) |-> !exc_req)
        else $error("no-wait instruction saw exception");

endmodule

// File: rtl/fpu_restore_seq.sv
module fpu_restore_seq
    import fpr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_ST    = 8,
    parameter int REG_BYTES = 10,
    parameter int ALIGN_LG2 = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          mode32,
    input  logic [ADDR_W-1:0]             base_addr,
    input  logic                          cr_em,
    input  logic                          cr_ts,
    input  logic                          lock_pfx,
    input  logic                          align_chk,
    input  logic [1:0]                    cpl,
    output logic                          mem_req,
    output logic [ADDR_W-1:0]             mem_addr,
    input  logic [15:0]                   mem_rdata,
    input  logic                          mem_rvalid,
    input  logic                          mem_fault,
    output logic                          busy,
    output logic                          done,
    output logic                          fault_valid,
    output logic [2:0]                    fault_code,
    output logic [15:0]                   fpu_ctrl,
    output logic [15:0]                   fpu_stat,
    output logic [15:0]                   fpu_tag,
    output logic [31:0]                   fpu_dp,
    output logic [31:0]                   fpu_ip,
    output logic [10:0]                   fpu_opc,
    output logic [NUM_ST*REG_BYTES*8-1:0] fpu_st,
    output logic                          pend_exc,
    input  logic                          fp_issue,
    input  logic                          fp_nowait,
    output logic                          fp_exc_req
);

    localparam int REG_WORDS = REG_BYTES / 2;
    localparam int RIDX_W    = $clog2(NUM_ST);
    localparam int PART_W    = $clog2(REG_WORDS);

    fault_e                              pre_fault;
    fault_e                              seq_fault;
    logic                                mode_wide;
    logic                                shadow_clr;
    logic                                cap_en;
    logic                                cap_env;
    logic [3:0]                          cap_env_idx;
    logic [RIDX_W-1:0]                   cap_reg;
    logic [PART_W-1:0]                   cap_part;
    logic                                commit;
    logic [15:0]                         sh_ctrl;
    logic [15:0]                         sh_stat;
    logic [NUM_ST-1:0][REG_WORDS*16-1:0] st_packed;

    fpr_precheck #(.ALIGN_LG2(ALIGN_LG2)) u_check (
        .lock_pfx  (lock_pfx),
        .cr_em     (cr_em),
        .cr_ts     (cr_ts),
        .align_chk (align_chk),
        .cpl       (cpl),
        .base_lo   (base_addr[ALIGN_LG2-1:0]),
        .pre_fault (pre_fault)
    );

    fpr_seq #(.ADDR_W(ADDR_W), .NUM_ST(NUM_ST), .REG_WORDS(REG_WORDS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode32      (mode32),
        .base_addr   (base_addr),
        .pre_fault   (pre_fault),
        .mem_rvalid  (mem_rvalid),
        .mem_fault   (mem_fault),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mode_wide   (mode_wide),
        .shadow_clr  (shadow_clr),
        .cap_en      (cap_en),
        .cap_env     (cap_env),
        .cap_env_idx (cap_env_idx),
        .cap_reg     (cap_reg),
        .cap_part    (cap_part),
        .commit      (commit),
        .busy        (busy),
        .done        (done),
        .fault_valid (fault_valid),
        .fault_code  (seq_fault)
    );

    assign fault_code = seq_fault;

    fpr_shadow #(.NUM_ST(NUM_ST), .REG_WORDS(REG_WORDS)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wide   (mode_wide),
        .shadow_clr  (shadow_clr),
        .cap_en      (cap_en),
        .cap_env     (cap_env),
        .cap_env_idx (cap_env_idx),
        .cap_reg     (cap_reg),
        .cap_part    (cap_part),
        .cap_data    (mem_rdata),
        .commit      (commit),
        .sh_ctrl     (sh_ctrl),
        .sh_stat     (sh_stat),
        .arch_ctrl   (fpu_ctrl),
        .arch_stat   (fpu_stat),
        .arch_tag    (fpu_tag),
        .arch_dp     (fpu_dp),
        .arch_ip     (fpu_ip),
        .arch_opc    (fpu_opc),
        .arch_st     (st_packed)
    );

    assign fpu_st = st_packed;

    fpr_pend u_pend (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit        (commit),
        .ld_ctrl_mask  (sh_ctrl[UM_BITS-1:0]),
        .ld_stat_flags (sh_stat[UM_BITS-1:0]),
        .fp_issue      (fp_issue),
        .fp_nowait     (fp_nowait),
        .pend          (pend_exc),
        .exc_req       (fp_exc_req)
    );

    // Locked form wins over every other check
    p_lock_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && lock_pfx) |=> (fault_valid && (fault_code == 3'd2) && !mem_req))
        else $error("lock prefix not reported first");

    // Unit unavailable: fault, no read
    p_unavail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !lock_pfx && (cr_em || cr_ts))
        |=> (fault_valid && (fault_code == 3'd1) && !mem_req))
        else $error("unavailable unit not reported");

    // Misaligned at privilege 3
    p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !lock_pfx && !cr_em && !cr_ts && align_chk && (cpl == 2'd3)
         && (|base_addr[ALIGN_LG2-1:0]))
        |=> (fault_valid && (fault_code == 3'd3) && !mem_req))
        else $error("alignment fault missing");

    // Fault pulse and done pulse never coincide
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault_valid))
        else $error("done and fault together");

endmodule

// File: tb/fpu_restore_seq_test.sv
module fpu_restore_seq_test;

    localparam int STW = 640;

    typedef struct packed {
        logic           flt;
        logic [2:0]     code;
        logic [7:0]     nreads;
        logic [15:0]    ctrl;
        logic [15:0]    stat;
        logic [15:0]    tag;
        logic [31:0]    dp;
        logic [31:0]    ip;
        logic [10:0]    opc;
        logic [STW-1:0] st;
        logic           pend;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            mode32 = 1'b0;
    logic [31:0]     base_addr = '0;
    logic            cr_em = 1'b0, cr_ts = 1'b0, lock_pfx = 1'b0, align_chk = 1'b0;
    logic [1:0]      cpl = 2'd0;
    logic            mem_req;
    logic [31:0]     mem_addr;
    logic [15:0]     mem_rdata = '0;
    logic            mem_rvalid = 1'b0, mem_fault = 1'b0;
    logic            busy, done, fault_valid;
    logic [2:0]      fault_code;
    logic [15:0]     fpu_ctrl, fpu_stat, fpu_tag;
    logic [31:0]     fpu_dp, fpu_ip;
    logic [10:0]     fpu_opc;
    logic [STW-1:0]  fpu_st;
    logic            pend_exc;
    logic            fp_issue = 1'b0, fp_nowait = 1'b0;
    logic            fp_exc_req;

    int errors = 0;
    int checks = 0;
    int ops_seen = 0;
    int rd_cnt = 0;
    int fault_at = -1;
    int cyc = 0;
    logic [31:0] op_base = '0;
    logic        hold_bad = 1'b0;
    logic [7:0]  mem [0:2047];
    item_t       sb_q[$];
    item_t       cur;
    item_t       held;

    always #2.5 clk = ~clk;

    fpu_restore_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode32(mode32), .base_addr(base_addr),
        .cr_em(cr_em), .cr_ts(cr_ts), .lock_pfx(lock_pfx), .align_chk(align_chk), .cpl(cpl),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .mem_fault(mem_fault), .busy(busy), .done(done),
        .fault_valid(fault_valid), .fault_code(fault_code), .fpu_ctrl(fpu_ctrl),
        .fpu_stat(fpu_stat), .fpu_tag(fpu_tag), .fpu_dp(fpu_dp), .fpu_ip(fpu_ip),
        .fpu_opc(fpu_opc), .fpu_st(fpu_st), .pend_exc(pend_exc), .fp_issue(fp_issue),
        .fp_nowait(fp_nowait), .fp_exc_req(fp_exc_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [STW-1:0] act, input logic [STW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] word_at(input logic [31:0] a);
        return {mem[(a + 32'd1) & 32'h7FF], mem[a & 32'h7FF]};
    endfunction

    task automatic put_word(input logic [31:0] a, input logic [15:0] w);
        mem[a & 32'h7FF]            = w[7:0];
        mem[(a + 32'd1) & 32'h7FF]  = w[15:8];
    endtask

    function automatic item_t expect_load(input logic [31:0] b, input bit wide);
        item_t e;
        int env;
        e = '0;
        if (!wide) begin
            env    = 7;
            e.ctrl = word_at(b);
            e.stat = word_at(b + 2);
            e.tag  = word_at(b + 4);
            e.dp   = {16'h0, word_at(b + 6)};
            e.ip   = {16'h0, word_at(b + 8)};
            e.opc  = word_at(b + 10) & 16'h07FF;
        end else begin
            env    = 14;
            e.ctrl = word_at(b);
            e.stat = word_at(b + 4);
            e.tag  = word_at(b + 8);
            e.dp   = {word_at(b + 14), word_at(b + 12)};
            e.ip   = {word_at(b + 18), word_at(b + 16)};
            e.opc  = word_at(b + 20) & 16'h07FF;
        end
        for (int r = 0; r < 8; r++) begin
            for (int p = 0; p < 5; p++) begin
                e.st[r*80 + p*16 +: 16] = word_at(b + 32'(2 * (env + 5*r + p)));
            end
        end
        e.pend   = |(e.stat[5:0] & ~e.ctrl[5:0]);
        e.nreads = 8'(env + 40);
        e.flt    = 1'b0;
        e.code   = 3'd0;
        return e;
    endfunction

    function automatic item_t observe();
        item_t o;
        o = '0;
        o.ctrl = fpu_ctrl; o.stat = fpu_stat; o.tag = fpu_tag;
        o.dp = fpu_dp; o.ip = fpu_ip; o.opc = fpu_opc; o.st = fpu_st; o.pend = pend_exc;
        return o;
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd1: return "R6";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R9";
            default: return "R5";
        endcase
    endfunction

    // Memory model with a stall every third cycle
    always begin
        @(negedge clk);
        cyc++;
        mem_rvalid = 1'b0;
        mem_fault  = 1'b0;
        if (mem_req && (cyc % 3 != 1)) begin
            if (rd_cnt == fault_at) begin
                mem_fault = 1'b1;
                fault_at  = -1;
            end else begin
                chk(mem_addr == op_base + 32'(2 * rd_cnt), "R2", "read address",
                    STW'(mem_addr), STW'(op_base + 32'(2 * rd_cnt)));
                mem_rdata  = word_at(mem_addr);
                mem_rvalid = 1'b1;
                rd_cnt++;
            end
        end
    end

    // Monitor: pop the expected outcome and compare
    always begin
        item_t e;
        item_t o;
        @(negedge clk);
        #1;
        o = observe();
        if (busy && !done && !fault_valid) begin
            if (o.ctrl != held.ctrl || o.stat != held.stat || o.tag != held.tag ||
                o.dp != held.dp || o.ip != held.ip || o.opc != held.opc || o.st != held.st)
                hold_bad = 1'b1;
        end
        if (done || fault_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R13", "unexpected completion", STW'(ops_seen), STW'(0));
            end else begin
                e = sb_q.pop_front();
                chk(fault_valid == e.flt, tag_of(e.code), "outcome kind",
                    STW'(fault_valid), STW'(e.flt));
                chk(fault_code == (e.flt ? e.code : 3'd0), tag_of(e.code), "fault code",
                    STW'(fault_code), STW'(e.code));
                chk(rd_cnt == int'(e.nreads), e.flt ? tag_of(e.code) : "R2", "read count",
                    STW'(rd_cnt), STW'(e.nreads));
                chk(o.ctrl == e.ctrl && o.tag == e.tag, "R3", "control/tag",
                    STW'({o.ctrl, o.tag}), STW'({e.ctrl, e.tag}));
                chk(o.dp == e.dp && o.ip == e.ip && o.opc == e.opc, "R3", "pointers/opcode",
                    STW'({o.dp, o.ip, o.opc}), STW'({e.dp, e.ip, e.opc}));
                chk(o.stat == e.stat, "R10", "status word", STW'(o.stat), STW'(e.stat));
                chk(o.st == e.st, "R4", "stack registers", o.st, e.st);
                chk(o.pend == e.pend, "R11", "pending flag", STW'(o.pend), STW'(e.pend));
                chk(!hold_bad, "R5", "state held during transfer", STW'(hold_bad), STW'(0));
            end
            ops_seen++;
        end
    end

    // Driver: predict the outcome, push it, launch the command
    task automatic run_op(input logic [31:0] b, input bit wide, input bit em, input bit ts,
                          input bit lk, input bit ac, input logic [1:0] pl, input int f_at,
                          input bit restart);
        item_t e;
        int target;
        logic [2:0] code;
        code = 3'd0;
        if (lk) code = 3'd2;
        else if (em || ts) code = 3'd1;
        else if (ac && pl == 2'd3 && b[1:0] != 2'b00) code = 3'd3;
        held = cur;
        if (code != 3'd0) begin
            e = cur; e.flt = 1'b1; e.code = code; e.nreads = 8'd0;
        end else if (f_at >= 0) begin
            e = cur; e.flt = 1'b1; e.code = 3'd4; e.nreads = 8'(f_at);
        end else begin
            e = expect_load(b, wide);
            cur = e;
            cur.flt = 1'b0; cur.code = 3'd0;
        end
        sb_q.push_back(e);
        target   = ops_seen + 1;
        @(negedge clk);
        op_base  = b;
        rd_cnt   = 0;
        fault_at = f_at;
        hold_bad = 1'b0;
        base_addr = b; mode32 = wide; cr_em = em; cr_ts = ts; lock_pfx = lk;
        align_chk = ac; cpl = pl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (6) @(negedge clk);
            base_addr = 32'h0700; mode32 = ~wide; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (ops_seen < target) @(negedge clk);
        cr_em = 0; cr_ts = 0; lock_pfx = 0; align_chk = 0; cpl = 0;
        repeat (8) @(negedge clk);
        chk(ops_seen == target && !busy, "R13", "single completion, idle after",
            STW'(ops_seen), STW'(target));
    endtask

    task automatic check_raise(input logic exp_pend);
        #2;
        fp_issue = 1'b1; fp_nowait = 1'b0; #1;
        chk(fp_exc_req == exp_pend, "R12", "waiting instruction", STW'(fp_exc_req), STW'(exp_pend));
        fp_nowait = 1'b1; #1;
        chk(fp_exc_req == 1'b0, "R12", "no-wait instruction", STW'(fp_exc_req), STW'(0));
        fp_issue = 1'b0; fp_nowait = 1'b0; #1;
        chk(fp_exc_req == 1'b0, "R11", "no issue, no exception", STW'(fp_exc_req), STW'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 4));
        cur = '0;
        cur.ctrl = 16'h037F;
        cur.tag  = 16'hFFFF;
        held = cur;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!busy && !mem_req && !done && !fault_valid, "R1", "idle after reset",
            STW'({busy, mem_req, done, fault_valid}), STW'(0));
        chk(fpu_ctrl == 16'h037F && fpu_tag == 16'hFFFF, "R1", "control/tag reset",
            STW'({fpu_ctrl, fpu_tag}), STW'({16'h037F, 16'hFFFF}));
        chk(fpu_stat == 0 && fpu_dp == 0 && fpu_ip == 0 && fpu_opc == 0 && fpu_st == 0 && !pend_exc,
            "R1", "other state reset", STW'(fpu_stat), STW'(0));

        // Narrow image, unmasked invalid-op flag, condition bits set
        put_word(32'h100, 16'h0370);
        put_word(32'h102, 16'h4701);
        run_op(32'h100, 1'b0, 0, 0, 0, 0, 2'd0, -1, 0);
        check_raise(1'b1);

        // Wide image, all flags masked
        put_word(32'h204, 16'h037F);
        put_word(32'h208, 16'h003F);
        run_op(32'h204, 1'b1, 0, 0, 0, 0, 2'd0, -1, 0);
        check_raise(1'b0);

        // Unavailable unit by either bit
        run_op(32'h300, 1'b0, 1, 0, 0, 0, 2'd0, -1, 0);
        run_op(32'h300, 1'b1, 0, 1, 0, 0, 2'd0, -1, 0);

        // Lock prefix outranks the others
        run_op(32'h301, 1'b0, 1, 0, 1, 1, 2'd3, -1, 0);

        // Misaligned at privilege 3 faults, at privilege 0 restores
        run_op(32'h301, 1'b0, 0, 0, 0, 1, 2'd3, -1, 0);
        put_word(32'h301, 16'h0000);
        put_word(32'h303, 16'h0002);
        run_op(32'h301, 1'b0, 0, 0, 0, 1, 2'd0, -1, 0);

        // Memory fault in the middle of the stack
        put_word(32'h400, 16'h003F);
        put_word(32'h404, 16'h0000);
        run_op(32'h400, 1'b1, 0, 0, 0, 0, 2'd0, 20, 0);
        check_raise(1'b1);

        // Restart attempt while busy
        put_word(32'h500, 16'h0030);
        put_word(32'h504, 16'h0020);
        run_op(32'h500, 1'b1, 0, 0, 0, 0, 2'd0, -1, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule